// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide transport stream of 188-byte packets and decides, once per packet, whether the whole packet is forwarded or dropped. Each packet is announced by a start strobe on its first byte, and that byte must be the sync value 0x47. The 13-bit packet identifier (PID) is read from the packet header. It is compared against a bank of programmable match slots. Two global controls can override the slots: one forwards everything and one blocks everything.

Software programs the slots through a simple write port. A single write replaces a whole slot word. The word for slot 0 also carries the three global control bits: pass-all, block-all and output byte order. The filter copies the whole configuration at the first byte of each packet. A packet is therefore judged only by the settings that were in force when it began. Forwarded bytes are packed four at a time into 32-bit words. A marker flags the final word of each packet.

Top module: `ts_pid_gate`

## Requirements
- R1: After reset every slot is disabled (enable clear, PID 0x1FFF) and all global bits are clear. The outputs are low and every packet is dropped.
- R2: A packet begins on a byte that has both in_valid and in_start high, and it covers the next 188 accepted bytes. Bytes that arrive while no packet is open are ignored.
- R3: A packet whose start byte is not 0x47 is dropped whole, and the filter stays idle until the next start strobe.
- R4: The PID is header byte 1 bits 4:0 followed by all of header byte 2. A packet passes when an enabled slot holds the same PID. A slot word carries its enable in bit 15 and its PID in bits 12:0. A disabled slot never matches, not even a packet whose PID is 0x1FFF.
- R5: When bit 16 of slot 0's word (pass-all) is set, every packet passes whatever its PID.
- R6: When bit 13 of slot 0's word (block-all) is set, every packet is dropped. This holds even when pass-all is also set or a slot matches.
- R7: A passed packet appears as exactly 47 words, and out_last marks the 47th. When bit 14 of slot 0's word is 0, the earliest byte is placed in bits 31:24. When that bit is 1, the earliest byte is placed in bits 7:0.
- R8: Each word is valid in the cycle that follows the clock edge accepting its fourth byte. Idle cycles on in_valid only stretch the timing.
- R9: The configuration is sampled at each packet's start byte. A write made later, during the packet, affects only the packets that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_start | input | 1 | Byte is the first of a packet |
| in_byte | input | 8 | Stream byte |
| cfg_we | input | 1 | Slot word write strobe |
| cfg_slot | input | 3 | Slot being written |
| cfg_wdata | input | 17 | Slot word (slot 0 also holds the global bits) |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Four packed stream bytes |
| out_last | output | 1 | Final word of a forwarded packet |

## Verification
Four stream bytes go into each output word. Word j of a packet is therefore due one edge after the byte at index 4j+3 is accepted, or after 4j+4 bytes counting from the start byte. The drop or pass decision is already latched at byte 2. The bench records the cycle in which it drives every byte and the cycle in which every word appears, and it compares the two one word at a time. This holds both with and without idle gaps on in_valid. A mid-packet write is placed at a known byte index. The bench then checks that the current packet is unaffected and that the following packet sees the change.

// File: rtl/ts_pid_gate.sv
module ts_pid_gate #(
  parameter int NSLOT = 8,
  parameter int PKT_BYTES = 188,
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_start,
  input  logic [7:0]               in_byte,
  input  logic                     cfg_we,
  input  logic [$clog2(NSLOT)-1:0] cfg_slot,
  input  logic [16:0]              cfg_wdata,
  output logic                     out_valid,
  output logic [31:0]              out_word,
  output logic                     out_last
);

  localparam int CW = $clog2(PKT_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(PKT_BYTES - 1);
  localparam logic [CW-1:0] PID_IDX = CW'(2);
  localparam int EN_BIT = 15;
  localparam int PASS_BIT = 16;
  localparam int ORDER_BIT = 14;
  localparam int BLOCK_BIT = 13;
  localparam logic [13:0] SLOT_OFF = 14'h1FFF;

  logic [NSLOT-1:0][13:0] live_slot, snap_slot;
  logic [2:0] live_glob, snap_glob;
  logic active, keep;
  logic [CW-1:0] cnt;
  logic [23:0] acc;

  wire [12:0] pid_now = {acc[4:0], in_byte};
  logic [NSLOT-1:0] hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_match
    assign hit[g] = snap_slot[g][13] && (snap_slot[g][12:0] == pid_now);
  end

  wire block_all = snap_glob[2];
  wire pass_all  = snap_glob[1];
  wire little    = snap_glob[0];
  wire decide    = !block_all && (pass_all || |hit);

  wire [31:0] word_be = {acc, in_byte};
  wire [31:0] word_le = {in_byte, acc[7:0], acc[15:8], acc[23:16]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_slot <= {NSLOT{SLOT_OFF}};
      snap_slot <= {NSLOT{SLOT_OFF}};
      live_glob <= '0;
      snap_glob <= '0;
      active    <= 1'b0;
      keep      <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (cfg_we) begin
        live_slot[cfg_slot] <= {cfg_wdata[EN_BIT], cfg_wdata[12:0]};
        if (cfg_slot == '0)
          live_glob <= {cfg_wdata[BLOCK_BIT], cfg_wdata[PASS_BIT], cfg_wdata[ORDER_BIT]};
      end
      if (in_valid) begin
        if (in_start) begin
          active <= (in_byte == SYNC_BYTE);
          keep   <= 1'b0;
          cnt    <= CW'(1);
          acc    <= {16'h0, in_byte};
          if (in_byte == SYNC_BYTE) begin
            snap_slot <= live_slot;
            snap_glob <= live_glob;
          end
        end else if (active) begin
          acc <= {acc[15:0], in_byte};
          cnt <= cnt + CW'(1);
          if (cnt == PID_IDX) keep <= decide;
          if (cnt[1:0] == 2'd3 && keep) begin
            out_valid <= 1'b1;
            out_word  <= little ? word_le : word_be;
            out_last  <= (cnt == LAST_IDX);
          end
          if (cnt == LAST_IDX) active <= 1'b0;
        end
      end
    end
  end

  assert_word_follows_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_last_is_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_block_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !block_all);

  assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !out_valid);

  assert_config_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(in_valid && in_start)) |=> ($stable(snap_slot) && $stable(snap_glob)));

endmodule

// File: tb/tb_ts_pid_gate.sv
module tb_ts_pid_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0;
  logic [7:0] in_byte = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_slot = '0;
  logic [16:0] cfg_wdata = '0;
  logic out_valid, out_last;
  logic [31:0] out_word;

  ts_pid_gate dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  longint cyc = 0;
  logic [7:0] pk [188];
  longint acc_cyc [188];
  int nw = 0;
  logic [31:0] wv [256];
  logic wl [256];
  longint wc [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (out_valid && nw < 256) begin
    wv[nw] = out_word; wl[nw] = out_last; wc[nw] = cyc; nw = nw + 1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic build(int pid, int sync, int seed);
    pk[0] = 8'(sync);
    pk[1] = {3'b010, 5'(pid >> 8)};
    pk[2] = 8'(pid);
    for (int k = 3; k < 188; k++) pk[k] = 8'(k * 7 + seed);
  endtask

  task automatic wr(int slot, logic [16:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(bit gaps, int wr_at = -1, int ws = 0, logic [16:0] wd = '0);
    for (int k = 0; k < 188; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (k == 0); in_byte = pk[k];
      cfg_we = (k == wr_at); cfg_slot = 3'(ws); cfg_wdata = wd;
      acc_cyc[k] = cyc + 1;
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0; in_start = 1'b0; cfg_we = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0; in_start = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_pkt(string tag, bit pass, bit le);
    int bad = -1, lastn = 0, tbad = -1;
    chk({tag, " word count"}, nw, pass ? 47 : 0);
    if (pass && nw == 47) begin
      for (int j = 0; j < 47; j++) begin
        logic [31:0] e;
        e = le ? {pk[4*j+3], pk[4*j+2], pk[4*j+1], pk[4*j]}
               : {pk[4*j], pk[4*j+1], pk[4*j+2], pk[4*j+3]};
        if (wv[j] !== e && bad < 0) bad = j;
        if (wl[j]) lastn++;
        if (wc[j] != acc_cyc[4*j+3] && tbad < 0) tbad = j;
      end
      chk({tag, " R7 first bad word"}, bad, -1);
      chk({tag, " R7 last marker on word 46"}, wl[46], 1);
      chk({tag, " R7 marker count"}, lastn, 1);
      chk({tag, " R8 first late word"}, tbad, -1);
    end
    nw = 0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_last after reset", out_last, 0);
    build(13'h1FFF, 8'h47, 1); send(0); expect_pkt("R1 pid 1FFF", 0, 0);
    build(13'h0000, 8'h47, 2); send(0); expect_pkt("R1 pid 0", 0, 0);
  endtask

  task automatic t_match();
    wr(3, 17'h08100);
    build(13'h0100, 8'h47, 3); send(0); expect_pkt("R4 slot match", 1, 0);
    build(13'h0101, 8'h47, 4); send(0); expect_pkt("R4 pid miss", 0, 0);
    build(13'h1FFF, 8'h47, 5); send(0); expect_pkt("R4 disabled 1FFF", 0, 0);
  endtask

  task automatic t_gaps();
    build(13'h0100, 8'h47, 6); send(1); expect_pkt("R8 gapped input", 1, 0);
  endtask

  task automatic t_pass_all();
    wr(0, 17'h11FFF);
    build(13'h0777, 8'h47, 7); send(0); expect_pkt("R5 pass-all", 1, 0);
  endtask

  task automatic t_block();
    wr(0, 17'h13FFF);
    build(13'h0100, 8'h47, 8); send(0); expect_pkt("R6 block over pass and match", 0, 0);
    wr(0, 17'h01FFF);
  endtask

  task automatic t_order();
    wr(0, 17'h05FFF);
    build(13'h0100, 8'h47, 9); send(0); expect_pkt("R7 little order", 1, 1);
    wr(0, 17'h01FFF);
  endtask

  task automatic t_sync();
    build(13'h0100, 8'h46, 10); send(0); expect_pkt("R3 bad sync", 0, 0);
    build(13'h0100, 8'h47, 11); send(0); expect_pkt("R3 recovery", 1, 0);
  endtask

  task automatic t_stray();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); in_valid = 1'b1; in_start = 1'b0; in_byte = (k == 0) ? 8'h47 : 8'(k);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 stray bytes ignored", nw, 0);
    nw = 0;
  endtask

  task automatic t_boundary();
    wr(2, 17'h08ABC);
    build(13'h0ABC, 8'h47, 12); send(0, 50, 2, 17'h01FFF);
    expect_pkt("R9 disable mid-packet", 1, 0);
    build(13'h0ABC, 8'h47, 13); send(0); expect_pkt("R9 disable applied", 0, 0);
    build(13'h0ABC, 8'h47, 14); send(0, 1, 2, 17'h08ABC);
    expect_pkt("R9 enable mid-packet", 0, 0);
    build(13'h0ABC, 8'h47, 15); send(0); expect_pkt("R9 enable applied", 1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_gaps();
    t_pass_all();
    t_block();
    t_order();
    t_sync();
    t_stray();
    t_boundary();
    summary();
    $finish;
  end
endmodule